// File: doc/BRIEF.md
# Decode-Stage Branch Redirect and Fetch Address Unit

This block owns the fetch program counter of a five-stage in-order pipeline and resolves control transfers while the instruction sits in decode. A zero/non-zero comparator and a dedicated target adder live beside the decode stage. A taken conditional branch or a jump therefore redirects fetch on the very next clock edge, which costs one cycle instead of waiting for the execute or memory stage.

A configuration input picks how the single instruction already fetched behind a taken transfer is treated. In squash mode, which predicts not taken, that instruction is killed by a squash strobe that clears its valid bit as it enters the IF/ID register. In delay-slot mode that instruction is architecturally executed and is never squashed. A stall input freezes the fetch address and suppresses the squash, so a stalled transfer is resolved once the stall lifts.

Top module: `early_redirect_unit`

## Requirements
- R1: While reset is held and right after it is released, `fetchPc` equals the reset address 0x0000_1000 and `squashFetch` is low.
- R2: With no stall and no valid control transfer in decode, `fetchPc` grows by 4 on each rising clock edge.
- R3: While `stall` is high, `fetchPc` keeps its value across the edge and `squashFetch` stays low, even when a taken transfer sits in decode.
- R4: A valid instruction with opcode bits 31:26 = 6'h04 (branch if zero) is taken when `srcVal` is zero. `fetchPc` then becomes `idPc` + 4 + (sign-extended bits 15:0 shifted left by 2) at the next edge, and negative offsets move backwards.
- R5: A valid instruction with opcode 6'h05 (branch if non-zero) is taken when `srcVal` is not zero, with the same target rule as R4.
- R6: A branch whose condition fails is not taken: `fetchPc` advances by 4 and `squashFetch` stays low.
- R7: A valid instruction with opcode 6'h02 (jump) always redirects. The target is bits 31:28 of `idPc` + 4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R8: With `delaySlotMode` low, `squashFetch` is high in the same cycle as a taken branch or jump that is redirecting fetch.
- R9: With `delaySlotMode` high, `squashFetch` is never asserted, and taken transfers redirect at the same edge as in R8.
- R10: When `idValid` is low, the decode contents are ignored: no redirect and no squash.
- R11: Any other opcode (for example 6'h06 or 6'h08) is treated as sequential, whatever the value of `srcVal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze fetch and hold the decode instruction |
| delaySlotMode | input | 1 | 1: one architectural delay slot; 0: squash on taken |
| idValid | input | 1 | Decode-stage instruction is valid |
| idPc | input | 32 | Address of the instruction in decode |
| idInstr | input | 32 | Instruction word in decode |
| srcVal | input | 32 | Value of the first source register of the decode instruction |
| fetchPc | output | 32 | Address presented to instruction fetch |
| squashFetch | output | 1 | Kill the instruction now in fetch (clear its IF/ID valid) |

## Verification
Any corruption of the fetch counter or of the target arithmetic shows on `fetchPc` at the first rising edge after the faulty decode cycle. A wrong sign extension or a misplaced jump field gives an address that differs in predictable bit positions. A wrong squash decision is visible in the same cycle as the redirect, before the edge. This lets each scenario pair the squash check taken before the edge with the address check taken after it. Stall errors show up as an address that moves, or a squash that appears, while the stall is held.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int INSTR_W   = 32;
  localparam int OPCODE_W  = 6;
  localparam int OFFSET_W  = 16;
  localparam int JFIELD_W  = 26;
  localparam int OPCODE_LSB = INSTR_W - OPCODE_W;

  localparam logic [OPCODE_W-1:0] OP_JUMP   = 6'h02;
  localparam logic [OPCODE_W-1:0] OP_BRZERO = 6'h04;
  localparam logic [OPCODE_W-1:0] OP_BRNZ   = 6'h05;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;        // keep the fetch address
    logic takeJump;    // load jump target
    logic takeBranch;  // load branch target
    logic squash;      // kill the instruction in fetch
  } pc_ctrl_t;
endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
(
  input  logic                stall,
  input  logic                delaySlotMode,
  input  logic                idValid,
  input  logic [OPCODE_W-1:0] opcode,
  input  logic                srcIsZero,
  output pc_ctrl_t            ctrl
);
  logic isBrZero, isBrNz, isJump, condMet;

  always_comb begin
    isBrZero = idValid && (opcode == OP_BRZERO);
    isBrNz   = idValid && (opcode == OP_BRNZ);
    isJump   = idValid && (opcode == OP_JUMP);
    condMet  = (isBrZero && srcIsZero) || (isBrNz && !srcIsZero);

    ctrl.hold       = stall;
    ctrl.takeJump   = isJump && !stall;
    ctrl.takeBranch = condMet && !stall;
    ctrl.squash     = (ctrl.takeJump || ctrl.takeBranch) && !delaySlotMode;
  end
endmodule

// File: rtl/nextpc_datapath.sv
module nextpc_datapath
  import nextpc_pkg::*;
#(
  parameter int                 ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]  RESET_PC = 32'h0000_1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pc_ctrl_t            ctrl,
  input  logic [ADDR_W-1:0]   idPc,
  input  logic [OFFSET_W-1:0] brOffset,
  input  logic [JFIELD_W-1:0] jumpField,
  input  logic [ADDR_W-1:0]   srcVal,
  output logic                srcIsZero,
  output logic [ADDR_W-1:0]   fetchPc
);
  localparam int EXT_W    = ADDR_W - OFFSET_W - 2;
  localparam int REGION_W = ADDR_W - JFIELD_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pcReg, seqPc, linkPc, offsetExt, branchTarget, jumpTarget, nextPc;

  always_comb begin
    srcIsZero    = (srcVal == '0);
    seqPc        = pcReg + STEP;
    linkPc       = idPc + STEP;
    offsetExt    = {{EXT_W{brOffset[OFFSET_W-1]}}, brOffset, 2'b00};
    branchTarget = linkPc + offsetExt;
    jumpTarget   = {linkPc[ADDR_W-1 -: REGION_W], jumpField, 2'b00};

    if (ctrl.hold)            nextPc = pcReg;
    else if (ctrl.takeJump)   nextPc = jumpTarget;
    else if (ctrl.takeBranch) nextPc = branchTarget;
    else                      nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pcReg <= RESET_PC;
    else        pcReg <= nextPc;
  end

  assign fetchPc = pcReg;
endmodule

// File: rtl/early_redirect_unit.sv
module early_redirect_unit
  import nextpc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              delaySlotMode,
  input  logic              idValid,
  input  logic [ADDR_W-1:0] idPc,
  input  logic [INSTR_W-1:0] idInstr,
  input  logic [ADDR_W-1:0] srcVal,
  output logic [ADDR_W-1:0] fetchPc,
  output logic              squashFetch
);
  pc_ctrl_t ctrl;
  logic     srcIsZero;

  nextpc_ctrl u_ctrl (
    .stall         (stall),
    .delaySlotMode (delaySlotMode),
    .idValid       (idValid),
    .opcode        (idInstr[INSTR_W-1:OPCODE_LSB]),
    .srcIsZero     (srcIsZero),
    .ctrl          (ctrl)
  );

  nextpc_datapath #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .idPc      (idPc),
    .brOffset  (idInstr[OFFSET_W-1:0]),
    .jumpField (idInstr[JFIELD_W-1:0]),
    .srcVal    (srcVal),
    .srcIsZero (srcIsZero),
    .fetchPc   (fetchPc)
  );

  assign squashFetch = ctrl.squash;
endmodule

// File: rtl/nextpc_checker.sv
module nextpc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              delaySlotMode,
  input logic              idValid,
  input logic [31:0]       idInstr,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              squashFetch
);
  logic ctlOp;
  assign ctlOp = idValid && (idInstr[31:26] == 6'h02 || idInstr[31:26] == 6'h04 ||
                             idInstr[31:26] == 6'h05);

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !ctlOp) |=> fetchPc == $past(fetchPc) + ADDR_W'(4));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetchPc));

  assert_stall_no_squash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !squashFetch);

  assert_squash_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squashFetch |-> (ctlOp && !stall && !delaySlotMode));

  assert_delay_no_squash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    delaySlotMode |-> !squashFetch);

  assert_invalid_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !idValid |-> !squashFetch);
endmodule

bind early_redirect_unit nextpc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .delaySlotMode(delaySlotMode),
  .idValid(idValid), .idInstr(idInstr), .fetchPc(fetchPc), .squashFetch(squashFetch)
);

// File: tb/sim_early_redirect_unit.sv
module sim_early_redirect_unit;
  logic        clk = 1'b0;
  logic        rst_n, stall, delaySlotMode, idValid;
  logic [31:0] idPc, idInstr, srcVal, fetchPc;
  logic        squashFetch;
  int          checks = 0, fails = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  early_redirect_unit u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .delaySlotMode(delaySlotMode),
    .idValid(idValid), .idPc(idPc), .idInstr(idInstr), .srcVal(srcVal),
    .fetchPc(fetchPc), .squashFetch(squashFetch)
  );

  function automatic logic [31:0] mkBr(logic [5:0] op, logic [15:0] off);
    return {op, 5'd3, 5'd0, off};
  endfunction

  function automatic logic [31:0] mkJump(logic [25:0] field);
    return {6'h02, field};
  endfunction

  task automatic checkVal(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setIn(logic v, logic [31:0] pc, logic [31:0] ins, logic [31:0] src);
    idValid = v; idPc = pc; idInstr = ins; srcVal = src;
  endtask

  // inputs already set at a falling edge; check squash, then the next address
  task automatic stepCheck(string req, logic expSq, logic [31:0] expPc);
    #1;
    checkVal({req, " squash"}, {31'b0, squashFetch}, {31'b0, expSq});
    @(posedge clk);
    @(negedge clk);
    checkVal({req, " fetchPc"}, fetchPc, expPc);
  endtask

  task automatic doReset(logic mode);
    rst_n = 1'b0; stall = 1'b0; delaySlotMode = mode;
    setIn(1'b0, 32'h0, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    checkVal("R1 reset fetchPc held", fetchPc, 32'h0000_1000);
    rst_n = 1'b1;
    #1;
    checkVal("R1 reset fetchPc", fetchPc, 32'h0000_1000);
    checkVal("R1 reset squash", {31'b0, squashFetch}, 32'h0);
  endtask

  task automatic testSequential();
    doReset(1'b0);
    stepCheck("R2 seq1", 1'b0, 32'h0000_1004);
    stepCheck("R2 seq2", 1'b0, 32'h0000_1008);
    stepCheck("R2 seq3", 1'b0, 32'h0000_100C);
  endtask

  task automatic testStall();
    doReset(1'b0);
    stepCheck("R2 pre", 1'b0, 32'h0000_1004);
    stall = 1'b1;
    setIn(1'b1, 32'h0000_1000, mkBr(6'h04, 16'h0010), 32'h0);
    stepCheck("R3 stall1", 1'b0, 32'h0000_1004);
    stepCheck("R3 stall2", 1'b0, 32'h0000_1004);
    stall = 1'b0;
    stepCheck("R4 after stall", 1'b1, 32'h0000_1044);
    setIn(1'b0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic testBrZero();
    doReset(1'b0);
    setIn(1'b1, 32'h0000_1000, mkBr(6'h04, 16'h0003), 32'h0);
    stepCheck("R4 R8 fwd", 1'b1, 32'h0000_1010);
    setIn(1'b1, 32'h0000_1010, mkBr(6'h04, 16'hFFFE), 32'h0);
    stepCheck("R4 R8 back", 1'b1, 32'h0000_100C);
    setIn(1'b1, 32'h0000_100C, mkBr(6'h04, 16'h0040), 32'h5);
    stepCheck("R6 brzero fail", 1'b0, 32'h0000_1010);
    setIn(1'b0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic testBrNz();
    doReset(1'b0);
    setIn(1'b1, 32'h0000_2000, mkBr(6'h05, 16'h0004), 32'h7);
    stepCheck("R5 R8 taken", 1'b1, 32'h0000_2014);
    setIn(1'b1, 32'h0000_2014, mkBr(6'h05, 16'h0004), 32'h0);
    stepCheck("R6 brnz fail", 1'b0, 32'h0000_2018);
    setIn(1'b0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic testJump();
    doReset(1'b0);
    setIn(1'b1, 32'hA000_0100, mkJump(26'h0123456), 32'h0);
    stepCheck("R7 R8 jump", 1'b1, 32'hA048_D158);
    setIn(1'b0, 32'h0, 32'h0, 32'h0);
    stepCheck("R2 after jump", 1'b0, 32'hA048_D15C);
  endtask

  task automatic testDelay();
    doReset(1'b1);
    setIn(1'b1, 32'h0000_1000, mkBr(6'h04, 16'h0003), 32'h0);
    stepCheck("R9 delay branch", 1'b0, 32'h0000_1010);
    setIn(1'b1, 32'h0000_1010, mkJump(26'h0000400), 32'h0);
    stepCheck("R9 delay jump", 1'b0, 32'h0000_1000);
    setIn(1'b0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic testInvalid();
    doReset(1'b0);
    setIn(1'b0, 32'h0000_1000, mkBr(6'h04, 16'h0020), 32'h0);
    stepCheck("R10 invalid branch", 1'b0, 32'h0000_1004);
    setIn(1'b0, 32'h0000_1004, mkJump(26'h0000800), 32'h0);
    stepCheck("R10 invalid jump", 1'b0, 32'h0000_1008);
  endtask

  task automatic testOther();
    doReset(1'b0);
    setIn(1'b1, 32'h0000_1000, mkBr(6'h08, 16'h0020), 32'h0);
    stepCheck("R11 op08", 1'b0, 32'h0000_1004);
    setIn(1'b1, 32'h0000_1004, mkBr(6'h06, 16'h0020), 32'h9);
    stepCheck("R11 op06", 1'b0, 32'h0000_1008);
    setIn(1'b0, 32'h0, 32'h0, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; delaySlotMode = 1'b0;
    setIn(1'b0, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    testSequential();
    testStall();
    testBrZero();
    testBrNz();
    testJump();
    testDelay();
    testInvalid();
    testOther();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule